// File: doc/BRIEF.md
# Speculative Variable-Latency Prefix Adder

This block adds two unsigned operands of `WIDTH` bits and returns the sum and carry-out. A full carry-prefix network over the whole word takes log2(WIDTH) merge levels. The fast path instead runs only the first log2(SPAN) levels, so each position sees at most a `SPAN`-bit propagate chain. It treats the group generate of that truncated window as the carry into the next bit. In the same cycle a detector looks for any operand pattern that could make one of those truncated carries wrong. If no such pattern is found, the fast result is registered at once and appears one cycle after acceptance.

When the detector fires, the fast result is thrown away. The block registers the window-level group signals and the bit propagates, and then runs only the remaining prefix levels on those held values. The exact result is registered one cycle later. During that correction cycle the block takes no new operands.

Operands enter through a valid/ready handshake. A transfer happens on a rising edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must hold `in_valid` and its operands until the block accepts them. Whatever is on the inputs in a cycle where `in_ready` is low has no effect. The result side cannot be stalled. `out_valid` is high for exactly one cycle per accepted pair, and the consumer must take the result in that cycle. Results leave in acceptance order. `out_slow` marks a result that came through the correction path. Here "propagate" on bit k means `in_a[k] XOR in_b[k]` and "generate" means `in_a[k] AND in_b[k]`.

Top module: `spec_prefix_adder`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises with no transfer, `out_valid` and `out_slow` are 0 and `in_ready` is 1.
- R2: A pair that is accepted and not flagged gives `out_valid` = 1 and `out_slow` = 0 on the very next cycle.
- R3: A pair is flagged exactly when some bit position i >= SPAN meets two conditions. First, bits i-SPAN+1 through i all propagate. Second, the segment that ends at bit j = i-SPAN and starts at bit max(0, j-SPAN+1) either generates a carry out of bit j on its own or propagates on every one of its bits. The flag is conservative, so some flagged pairs had a correct fast result.
- R4: On the cycle after a flagged pair is accepted, `in_ready` and `out_valid` are both 0. On the cycle after that, `out_valid` = 1, `out_slow` = 1 and `in_ready` = 1.
- R5: `in_valid` and operands presented while `in_ready` is 0 are ignored and never produce a result.
- R6: Every result with `out_valid` = 1 is exact on both paths: `out_sum` = (a + b) mod 2^WIDTH and `out_carry` = bit WIDTH of a + b.
- R7: A cycle with no transfer leaves `out_valid` at 0 on the next cycle, unless a correction is finishing.
- R8: When unflagged pairs arrive on consecutive cycles, one result appears on every cycle, in arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can accept a pair this cycle |
| in_a | input | WIDTH | First operand |
| in_b | input | WIDTH | Second operand |
| out_valid | output | 1 | Result present for this cycle only |
| out_sum | output | WIDTH | Sum modulo 2^WIDTH |
| out_carry | output | 1 | Carry out of the top bit |
| out_slow | output | 1 | Result came through the correction cycle |

## Verification
The assertions check the handshake timing on every cycle. An unflagged transfer yields a fast result on the next edge. A flagged one drops `in_ready` for exactly one cycle and then yields a slow result. Idle cycles produce no output. The correction tree never reports a group that both generates and propagates. Only the bench's scenarios can show that the sums are numerically right and that the flag matches the rule in R3. Those scenarios include long propagate chains that end in a carry, chains with no carry, chains exactly `SPAN` bits long, all-ones inputs, and inputs offered while stalled. The bench shows these by comparing against an arithmetic model.

// File: rtl/spa_pkg.sv
package spa_pkg;

  // Group carry signals of one bit position: generate and propagate.
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Combine a higher group with the adjacent lower group.
  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/spa_pregp.sv
module spa_pregp
  import spa_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output gp_t  [W-1:0] gp_bit,
  output logic [W-1:0] prop
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gp_bit[i].g = op_a[i] & op_b[i];
    assign gp_bit[i].p = op_a[i] ^ op_b[i];
  end

  assign prop = op_a ^ op_b;

endmodule

// File: rtl/spa_ks_levels.sv
// A run of NUM uniform prefix levels. Level l reaches back 2**(FIRST+l)
// positions, so the same module builds both the speculative front and the
// correction tail of the tree.
module spa_ks_levels
  import spa_pkg::*;
#(
  parameter int W     = 64,
  parameter int FIRST = 0,
  parameter int NUM   = 3
) (
  input  gp_t [W-1:0] gp_in,
  output gp_t [W-1:0] gp_out
);

  gp_t [W-1:0] st [NUM+1];

  assign st[0] = gp_in;

  for (genvar l = 0; l < NUM; l++) begin : g_lvl
    localparam int DIST = 1 << (FIRST + l);
    for (genvar i = 0; i < W; i++) begin : g_pos
      if (i >= DIST) begin : g_cell
        assign st[l+1][i] = gp_merge(st[l][i], st[l][i-DIST]);
      end else begin : g_pass
        assign st[l+1][i] = st[l][i];
      end
    end
  end

  assign gp_out = st[NUM];

endmodule

// File: rtl/spa_miss_detect.sv
// Flags any position whose truncated window fully propagates while the
// window just below it may deliver a carry (conservative).
module spa_miss_detect
  import spa_pkg::*;
#(
  parameter int W    = 64,
  parameter int SPAN = 8
) (
  input  gp_t [W-1:0] win,
  output logic        miss
);

  always_comb begin
    miss = 1'b0;
    for (int i = SPAN; i < W; i++) begin
      miss = miss | (win[i].p & (win[i-SPAN].g | win[i-SPAN].p));
    end
  end

endmodule

// File: rtl/spa_post.sv
module spa_post #(
  parameter int W = 64
) (
  input  logic [W-1:0] grp_g,
  input  logic [W-1:0] prop,
  output logic [W-1:0] sum,
  output logic         carry
);

  logic [W-1:0] cin_vec;

  assign cin_vec = {grp_g[W-2:0], 1'b0};
  assign sum     = prop ^ cin_vec;
  assign carry   = grp_g[W-1];

endmodule

// File: rtl/spec_prefix_adder.sv
module spec_prefix_adder
  import spa_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int SPAN  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_sum,
  output logic             out_carry,
  output logic             out_slow
);

  localparam int LOG_W     = $clog2(WIDTH);
  localparam int SPEC_LVLS = $clog2(SPAN);
  localparam int FIX_LVLS  = LOG_W - SPEC_LVLS;

  gp_t [WIDTH-1:0] bit_gp, spec_gp, hold_gp, fix_gp;
  logic [WIDTH-1:0] bit_p, hold_p;
  logic [WIDTH-1:0] spec_g_v, fix_g_v, fix_p_v;
  logic [WIDTH-1:0] fast_sum, slow_sum;
  logic             fast_carry, slow_carry;
  logic             spec_miss, busy, take;

  // Pre-processing and speculative front of the tree.
  spa_pregp #(.W(WIDTH)) u_pre (
    .op_a  (in_a),
    .op_b  (in_b),
    .gp_bit(bit_gp),
    .prop  (bit_p)
  );

  spa_ks_levels #(.W(WIDTH), .FIRST(0), .NUM(SPEC_LVLS)) u_spec (
    .gp_in (bit_gp),
    .gp_out(spec_gp)
  );

  spa_miss_detect #(.W(WIDTH), .SPAN(SPAN)) u_det (
    .win (spec_gp),
    .miss(spec_miss)
  );

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      spec_g_v[i] = spec_gp[i].g;
      fix_g_v[i]  = fix_gp[i].g;
      fix_p_v[i]  = fix_gp[i].p;
    end
  end

  spa_post #(.W(WIDTH)) u_fast (
    .grp_g(spec_g_v),
    .prop (bit_p),
    .sum  (fast_sum),
    .carry(fast_carry)
  );

  // Correction: the pruned levels, fed from the held speculative groups.
  spa_ks_levels #(.W(WIDTH), .FIRST(SPEC_LVLS), .NUM(FIX_LVLS)) u_fix (
    .gp_in (hold_gp),
    .gp_out(fix_gp)
  );

  spa_post #(.W(WIDTH)) u_slow (
    .grp_g(fix_g_v),
    .prop (hold_p),
    .sum  (slow_sum),
    .carry(slow_carry)
  );

  assign in_ready = ~busy;
  assign take     = in_valid & ~busy;

  always_ff @(posedge clk) begin
    if (take && spec_miss) begin
      hold_gp <= spec_gp;
      hold_p  <= bit_p;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      out_slow  <= 1'b0;
      out_sum   <= '0;
      out_carry <= 1'b0;
    end else if (busy) begin
      busy      <= 1'b0;
      out_valid <= 1'b1;
      out_slow  <= 1'b1;
      out_sum   <= slow_sum;
      out_carry <= slow_carry;
    end else if (take && spec_miss) begin
      busy      <= 1'b1;
      out_valid <= 1'b0;
      out_slow  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_slow  <= 1'b0;
      out_sum   <= fast_sum;
      out_carry <= fast_carry;
    end else begin
      out_valid <= 1'b0;
      out_slow  <= 1'b0;
    end
  end

  // R2: an unflagged transfer returns a fast result on the next edge.
  p_fast_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !spec_miss) |=> (out_valid && !out_slow));

  // R4: a flagged transfer stalls intake and withholds output for one cycle.
  p_stall_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && spec_miss) |=> (!in_ready && !out_valid));

  // R4: the stall lasts exactly one cycle and ends with a slow result.
  p_stall_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (in_ready && out_valid && out_slow));

  // R7: no transfer and no pending correction means no result.
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);

  // R6: a group in the exact tree can never both generate and propagate.
  p_fix_groups_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((fix_g_v & fix_p_v) == '0));

endmodule

// File: tb/spec_prefix_adder_tb_top.sv
module spec_prefix_adder_tb_top;

  localparam int W  = 64;
  localparam int SP = 8;
  typedef logic [W:0] wide_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [W-1:0] in_a, in_b;
  logic         out_valid;
  logic [W-1:0] out_sum;
  logic         out_carry;
  logic         out_slow;

  int n_checks = 0;
  int n_fails  = 0;

  always #2 clk = ~clk;

  spec_prefix_adder #(.WIDTH(W), .SPAN(SP)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_a     (in_a),
    .in_b     (in_b),
    .out_valid(out_valid),
    .out_sum  (out_sum),
    .out_carry(out_carry),
    .out_slow (out_slow)
  );

  task automatic chk(input bit ok, input string tag, input wide_t act, input wide_t exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Flag rule written straight from the requirement text.
  function automatic bit pred_flag(logic [W-1:0] a, logic [W-1:0] b);
    for (int i = SP; i < W; i++) begin
      bit allp = 1'b1;
      for (int k = i - SP + 1; k <= i; k++) allp = allp & (a[k] ^ b[k]);
      if (allp) begin
        int j  = i - SP;
        int lo = (j - SP + 1 < 0) ? 0 : j - SP + 1;
        bit gw = 1'b0;
        bit pw = 1'b1;
        for (int k = lo; k <= j; k++) begin
          gw = (a[k] & b[k]) | ((a[k] ^ b[k]) & gw);
          pw = pw & (a[k] ^ b[k]);
        end
        if (gw || pw) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  // Cycle model of the handshake and results.
  bit    m_busy;
  wide_t m_hold;
  bit    e_valid, e_slow;
  wide_t e_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy  <= 1'b0;
      e_valid <= 1'b0;
      e_slow  <= 1'b0;
    end else if (m_busy) begin
      m_busy  <= 1'b0;
      e_valid <= 1'b1;
      e_slow  <= 1'b1;
      e_res   <= m_hold;
    end else if (in_valid) begin : acc
      wide_t r;
      r = wide_t'(in_a) + wide_t'(in_b);
      if (pred_flag(in_a, in_b)) begin
        m_busy  <= 1'b1;
        m_hold  <= r;
        e_valid <= 1'b0;
        e_slow  <= 1'b0;
      end else begin
        e_valid <= 1'b1;
        e_slow  <= 1'b0;
        e_res   <= r;
      end
    end else begin
      e_valid <= 1'b0;
      e_slow  <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(in_ready === !m_busy, "R4 ready per cycle", wide_t'(in_ready), wide_t'(!m_busy));
      chk(out_valid === e_valid, "R2 valid per cycle", wide_t'(out_valid), wide_t'(e_valid));
      if (e_valid) begin
        chk({out_carry, out_sum} === e_res, "R6 sum per cycle", {out_carry, out_sum}, e_res);
        chk(out_slow === e_slow, "R3 path per cycle", wide_t'(out_slow), wide_t'(e_slow));
      end
    end
  end

  task automatic put(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_a     = a;
    in_b     = b;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_a     = '0;
    in_b     = '0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_slow === 1'b0 && in_ready === 1'b1, "R1 in reset",
        wide_t'({out_valid, out_slow, in_ready}), wide_t'(3'b001));
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && out_slow === 1'b0 && in_ready === 1'b1, "R1 after reset",
        wide_t'({out_valid, out_slow, in_ready}), wide_t'(3'b001));
    idle();
    chk(out_valid === 1'b0, "R7 idle", wide_t'(out_valid), '0);

    // Short operands: fast path.
    put(64'd1, 64'd1);
    idle();
    chk(out_valid === 1'b1 && out_slow === 1'b0, "R2 fast result", wide_t'({out_valid, out_slow}), wide_t'(2'b10));
    chk({out_carry, out_sum} === wide_t'(2), "R6 small sum", {out_carry, out_sum}, wide_t'(2));

    // Chain of SPAN-1 propagates: not flagged.
    put(64'hFF, 64'd1);
    idle();
    chk(out_valid === 1'b1 && out_slow === 1'b0, "R3 short chain unflagged", wide_t'({out_valid, out_slow}), wide_t'(2'b10));
    chk({out_carry, out_sum} === wide_t'(64'h100), "R6 short chain", {out_carry, out_sum}, wide_t'(64'h100));

    // Long chain fed by a carry: flagged, with an offer during the stall.
    put(64'hFFFF, 64'd1);
    put(64'd5, 64'd5);
    chk(in_ready === 1'b0 && out_valid === 1'b0, "R4 stall cycle", wide_t'({in_ready, out_valid}), '0);
    idle();
    chk(out_valid === 1'b1 && out_slow === 1'b1 && in_ready === 1'b1, "R4 slow result",
        wide_t'({out_valid, out_slow, in_ready}), wide_t'(3'b111));
    chk({out_carry, out_sum} === wide_t'(64'h10000), "R6 corrected sum", {out_carry, out_sum}, wide_t'(64'h10000));
    idle();
    chk(out_valid === 1'b0, "R5 stalled offer ignored", wide_t'(out_valid), '0);

    // All-propagate with no carry: flagged although exact.
    put(64'hFFFF, 64'd0);
    idle();
    chk(out_valid === 1'b0 && in_ready === 1'b0, "R3 conservative flag", wide_t'({out_valid, in_ready}), '0);
    idle();
    chk(out_slow === 1'b1 && {out_carry, out_sum} === wide_t'(64'hFFFF), "R3 conservative result",
        {out_carry, out_sum}, wide_t'(64'hFFFF));

    // Full-word chain with carry out.
    put('1, 64'd1);
    idle();
    idle();
    chk(out_valid === 1'b1 && {out_carry, out_sum} === {1'b1, {W{1'b0}}}, "R6 carry out",
        {out_carry, out_sum}, {1'b1, {W{1'b0}}});

    // Back-to-back fast transfers.
    for (int k = 1; k <= 12; k++) begin
      put(W'(k), W'(k));
      if (k > 1) chk(out_valid === 1'b1 && {out_carry, out_sum} === wide_t'(2 * (k - 1)), "R8 streaming",
                     {out_carry, out_sum}, wide_t'(2 * (k - 1)));
    end
    idle();
    chk(out_valid === 1'b1 && {out_carry, out_sum} === wide_t'(24), "R8 stream tail", {out_carry, out_sum}, wide_t'(24));
    idle();

    // Mixed traffic, biased toward long propagate chains.
    for (int n = 0; n < 4000; n++) begin
      logic [W-1:0] a, b;
      a = {$urandom, $urandom};
      case ($urandom % 3)
        0:       b = {$urandom, $urandom};
        1:       b = ~a ^ (W'(1) << ($urandom % W));
        default: begin
          b = ~a;
          b[7:0] = 8'($urandom);
        end
      endcase
      @(negedge clk);
      if (in_ready || !in_valid) begin
        in_valid = (($urandom % 4) != 0);
        in_a     = a;
        in_b     = b;
      end else if (($urandom % 2) == 0) begin
        in_a = a;
        in_b = b;
      end
    end
    idle();
    idle();
    idle();
    finish_run();
  end

endmodule